// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

The block couples two parallel buses, A and B, through two independent paths. The A-to-B path holds the value seen on bus A and can drive it onto bus B. The B-to-A path holds the value seen on bus B and can drive it onto bus A. Each path has one storage element whose behaviour is chosen at run time by that path's latch enable:

- **Latch enable high:** the element is a transparent latch.
- **Latch enable low:** it becomes a rising-edge register clocked by the path's own clock.
- **Latch enable low and clock steady:** it simply holds its value.

Every channel of a path shares that path's controls.

Each bus side is modelled as an input value, an output value and a drive enable, so that an enclosing testbench or pad ring can resolve it onto a three-state net. The A-to-B drive enable follows an active-high output enable. The B-to-A drive enable follows an active-low output enable. An active-low asynchronous reset clears both storage elements. Its release is synchronised separately to each path's clock.

Top module: `univ_bus_xcvr`

## Requirements
- R1: While a path's latch enable is high, that path's output equals its input bus value in the same time step, for every change of the input.
- R2: While the latch enable is low, a low-to-high transition of the path's clock stores the input value present at that edge, and the output shows it right after the edge.
- R3: With the latch enable low, neither a high-to-low clock transition nor a change of the input while the clock stays steady alters the output.
- R4: When the latch enable falls, the input value at that instant is held. This applies whether the clock is high or low at that moment. The held value is replaced only by a later rising clock edge taken with the latch enable low.
- R5: The B-side drive enable `b_oe` is 1 exactly when `oe_ab` is 1; with `oe_ab` at 0 the B side is released (high impedance).
- R6: The A-side drive enable `a_oe` is 1 exactly when `oe_ba_n` is 0; with `oe_ba_n` at 1 the A side is released.
- R7: The two paths are independent: clocking, latching or enabling one path leaves the other path's output unchanged.
- R8: While `rst_n` is 0 and the latch enable is low, both outputs are zero. After `rst_n` rises, the first two rising edges of a path's clock capture nothing; the third captures.
- R9: All WIDTH channels of a path (default 18) obey the same controls, so arbitrary full-width patterns pass through without any bit corrupted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B path |
| clk_ba | input | 1 | Capture clock of the B-to-A path |
| rst_n | input | 1 | Asynchronous active-low reset of both storage elements |
| oe_ab | input | 1 | Active-high output enable onto bus B |
| le_ab | input | 1 | Latch enable of the A-to-B path (1 = transparent) |
| oe_ba_n | input | 1 | Active-low output enable onto bus A |
| le_ba | input | 1 | Latch enable of the B-to-A path (1 = transparent) |
| a_in | input | WIDTH | Value present on bus A |
| a_out | output | WIDTH | Value the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Value present on bus B |
| b_out | output | WIDTH | Value the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench targets the moments where latch and register meet, one at a time:

- **Latch-enable fall with the clock high.** A design that captured on the enable's edge together with the clock would show a later input value here.
- **Latch-enable fall with the clock low.** The same error would surface with the clock in its low phase.
- **Input change during the clock's high phase, then its falling edge.** A design sensitive to both clock edges would pick up the new value.
- **Held value with no clock activity.** A latch left transparent would leak input changes to the output.

It also checks the two enable polarities against each other, because swapping them would drive the wrong bus. It checks that the reset-release delay lasts exactly two edges. Long random runs with full-width patterns then catch single-bit or cross-path corruption.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Polarity of a path's output enable input.
  typedef enum logic {
    OE_ACT_LOW  = 1'b0,
    OE_ACT_HIGH = 1'b1
  } oe_pol_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_ok = chain_q[STAGES-1];

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             le,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] reg_q;
  logic [WIDTH-1:0] reg_nxt;
  logic             reg_en;
  logic             use_reg_q;

  // Level-sensitive half: follows d while le is high, keeps the value at the fall.
  always_latch begin
    if (!rst_ok) begin
      lat_q = '0;
    end else if (le) begin
      lat_q = d;
    end
  end

  // Edge-triggered half: captures on a rising clock only while le is low.
  assign reg_en = !le;

  always_comb begin
    reg_nxt = reg_q;
    if (reg_en) begin
      reg_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      reg_q <= '0;
    end else begin
      reg_q <= reg_nxt;
    end
  end

  // Tracks which half holds the newest value: any le-high phase hands
  // ownership to the latch, a clock edge with le low hands it to the register.
  always_ff @(posedge clk or posedge le or negedge rst_ok) begin
    if (!rst_ok) begin
      use_reg_q <= 1'b0;
    end else if (le) begin
      use_reg_q <= 1'b0;
    end else begin
      use_reg_q <= 1'b1;
    end
  end

  assign q = le ? d : (use_reg_q ? reg_q : lat_q);

  assert_transparent_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    le |-> (q == d));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !le |=> (le || q == $past(d)));

  assert_fall_hold_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (!le && $past(le)) |-> (q == $past(d)));

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(rst_ok) |-> (le || q == '0));

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH  = 18,
  parameter oe_pol_e     OE_POL = OE_ACT_HIGH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le,
  input  logic             oe,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             drv
);

  logic rst_ok;

  xcvr_rst_sync #(
    .STAGES(RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ok(rst_ok)
  );

  xcvr_store #(
    .WIDTH(WIDTH)
  ) u_store (
    .clk   (clk),
    .rst_ok(rst_ok),
    .le    (le),
    .d     (d),
    .q     (q)
  );

  generate
    if (OE_POL == OE_ACT_HIGH) begin : g_oe_high
      assign drv = oe;
    end else begin : g_oe_low
      assign drv = !oe;
    end
  endgenerate

endmodule

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic             oe_ab,
  input  logic             le_ab,
  input  logic             oe_ba_n,
  input  logic             le_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  // A side to B side.
  xcvr_path #(
    .WIDTH (WIDTH),
    .OE_POL(OE_ACT_HIGH)
  ) u_path_ab (
    .clk  (clk_ab),
    .rst_n(rst_n),
    .le   (le_ab),
    .oe   (oe_ab),
    .d    (a_in),
    .q    (b_out),
    .drv  (b_oe)
  );

  // B side to A side.
  xcvr_path #(
    .WIDTH (WIDTH),
    .OE_POL(OE_ACT_LOW)
  ) u_path_ba (
    .clk  (clk_ba),
    .rst_n(rst_n),
    .le   (le_ba),
    .oe   (oe_ba_n),
    .d    (b_in),
    .q    (a_out),
    .drv  (a_oe)
  );

endmodule

// File: tb/univ_bus_xcvr_test.sv
module univ_bus_xcvr_test;

  localparam int unsigned WIDTH      = 18;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned HALF       = CLK_PERIOD / 2;

  logic             clk_ab, clk_ba, rst_n;
  logic             oe_ab, le_ab, oe_ba_n, le_ba;
  logic [WIDTH-1:0] ext_a, ext_b;
  logic             ext_a_en, ext_b_en;
  logic [WIDTH-1:0] a_out, b_out;
  logic             a_oe, b_oe;
  wire  [WIDTH-1:0] bus_a, bus_b;

  // Bench-side resolution of the two three-state buses.
  assign bus_a = a_oe     ? a_out : 'z;
  assign bus_a = ext_a_en ? ext_a : 'z;
  assign bus_b = b_oe     ? b_out : 'z;
  assign bus_b = ext_b_en ? ext_b : 'z;

  univ_bus_xcvr #(.WIDTH(WIDTH)) uut (
    .clk_ab (clk_ab),
    .clk_ba (clk_ba),
    .rst_n  (rst_n),
    .oe_ab  (oe_ab),
    .le_ab  (le_ab),
    .oe_ba_n(oe_ba_n),
    .le_ba  (le_ba),
    .a_in   (ext_a),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_in   (ext_b),
    .b_out  (b_out),
    .b_oe   (b_oe)
  );

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] held_ab, held_ba;

  function automatic logic [WIDTH-1:0] expect_out(input bit dir);
    if (dir == 1'b0) return le_ab ? ext_a : held_ab;
    return le_ba ? ext_b : held_ba;
  endfunction

  task automatic report(input string tag, input logic [WIDTH-1:0] act,
                        input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // dir 0 checks bus B (A-to-B path), dir 1 checks bus A (B-to-A path).
  task automatic check_out(input bit dir, input string tag);
    if ((a_oe && ext_a_en) || (b_oe && ext_b_en)) begin
      checks++;
      errors++;
      $display("FAIL %s: bus conflict actual a_oe=%b b_oe=%b expected none", tag, a_oe, b_oe);
    end
    if (dir == 1'b0) begin
      report(tag, b_out, expect_out(1'b0));
      if (b_oe) report(tag, bus_b, expect_out(1'b0));
    end else begin
      report(tag, a_out, expect_out(1'b1));
      if (a_oe) report(tag, bus_a, expect_out(1'b1));
    end
  endtask

  task automatic set_le(input bit dir, input logic v);
    if (dir == 1'b0) begin
      if (le_ab && !v) held_ab = ext_a;
      le_ab = v;
    end else begin
      if (le_ba && !v) held_ba = ext_b;
      le_ba = v;
    end
    #1;
  endtask

  task automatic set_d(input bit dir, input logic [WIDTH-1:0] v);
    if (dir == 1'b0) ext_a = v;
    else             ext_b = v;
    #1;
  endtask

  task automatic rise(input bit dir);
    if (dir == 1'b0) begin
      clk_ab = 1'b1;
      if (!le_ab) held_ab = ext_a;
    end else begin
      clk_ba = 1'b1;
      if (!le_ba) held_ba = ext_b;
    end
    #HALF;
  endtask

  task automatic fall(input bit dir);
    if (dir == 1'b0) clk_ab = 1'b0;
    else             clk_ba = 1'b0;
    #HALF;
  endtask

  task automatic pulse(input bit dir);
    rise(dir);
    fall(dir);
  endtask

  // Put one path onto its output bus; the external driver owns the other bus.
  task automatic select_dir(input bit dir);
    if (dir == 1'b0) begin
      oe_ba_n = 1'b1; ext_b_en = 1'b0; #1;
      oe_ab = 1'b1;   ext_a_en = 1'b1; #1;
    end else begin
      oe_ab = 1'b0;   ext_a_en = 1'b0; #1;
      oe_ba_n = 1'b0; ext_b_en = 1'b1; #1;
    end
  endtask

  task automatic directed(input bit dir);
    select_dir(dir);
    // R1: transparent following, two patterns
    set_le(dir, 1'b1);
    set_d(dir, 18'h15A5A); check_out(dir, "R1 follow first pattern");
    set_d(dir, 18'h2A5A5); check_out(dir, "R1 follow second pattern");
    pulse(dir);
    // R2: capture on rising edge with le low
    set_le(dir, 1'b0);
    set_d(dir, 18'h00F0F);
    rise(dir); check_out(dir, "R2 capture on rise");
    // R3: input changes during high phase, then falling edge
    set_d(dir, 18'h3FFFF);
    fall(dir); check_out(dir, "R3 no capture on fall");
    // R3: steady clock hold
    set_d(dir, 18'h12345); #(3 * HALF); check_out(dir, "R3 hold steady clock");
    // R2: next rising edge takes the new value
    pulse(dir); check_out(dir, "R2 capture after hold");
    // R4: le falls while clock is high
    set_le(dir, 1'b1);
    set_d(dir, 18'h0AAAA);
    rise(dir);
    set_le(dir, 1'b0);
    set_d(dir, 18'h35555); check_out(dir, "R4 fall with clock high");
    fall(dir); check_out(dir, "R4 hold after clock falls");
    pulse(dir); check_out(dir, "R4 later edge replaces value");
    // R4: le falls while clock is low
    set_le(dir, 1'b1);
    set_d(dir, 18'h1C3C3);
    pulse(dir);
    set_le(dir, 1'b0);
    set_d(dir, 18'h03C3C); check_out(dir, "R4 fall with clock low");
    pulse(dir); check_out(dir, "R4 edge after low-clock fall");
  endtask

  task automatic random_run(input bit dir, input int steps);
    select_dir(dir);
    for (int i = 0; i < steps; i++) begin
      logic le_v;
      le_v = ($urandom % 3) == 0;
      set_le(dir, le_v);
      set_d(dir, WIDTH'($urandom));
      check_out(dir, "R9 random patterns");
      if (le_v || ($urandom % 4) != 0) begin
        rise(dir);
        check_out(dir, "R9 random after edge");
        fall(dir);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    clk_ab = 1'b0; clk_ba = 1'b0; rst_n = 1'b0;
    oe_ab = 1'b0; oe_ba_n = 1'b1; le_ab = 1'b0; le_ba = 1'b0;
    ext_a = 18'h2AAAA; ext_b = 18'h15555; ext_a_en = 1'b1; ext_b_en = 1'b1;
    held_ab = '0; held_ba = '0;
    #(2 * CLK_PERIOD);
    // R8: cleared during reset, even with input activity
    report("R8 reset clears A-to-B", b_out, '0);
    report("R8 reset clears B-to-A", a_out, '0);
    // R5 and R6: both drivers released
    report("R5 B released", {17'd0, b_oe}, '0);
    report("R6 A released", {17'd0, a_oe}, '0);
    rst_n = 1'b1;
    #1;
    // R8: the first two edges after release capture nothing
    for (int k = 0; k < 2; k++) begin
      clk_ab = 1'b1; clk_ba = 1'b1; #HALF;
      clk_ab = 1'b0; clk_ba = 1'b0; #HALF;
    end
    report("R8 sync release A-to-B", b_out, '0);
    report("R8 sync release B-to-A", a_out, '0);
    pulse(1'b0); pulse(1'b1);
    report("R8 third edge captures A-to-B", b_out, 18'h2AAAA);
    report("R8 third edge captures B-to-A", a_out, 18'h15555);

    // R5 / R6 polarity
    oe_ab = 1'b1; ext_b_en = 1'b0; #1;
    report("R5 B driven", {17'd0, b_oe}, 18'd1);
    oe_ab = 1'b0; #1;
    ext_a_en = 1'b0; oe_ba_n = 1'b0; #1;
    report("R6 A driven", {17'd0, a_oe}, 18'd1);
    report("R5 B released again", {17'd0, b_oe}, '0);
    oe_ba_n = 1'b1; #1;
    report("R6 A released again", {17'd0, a_oe}, '0);
    ext_a_en = 1'b1; ext_b_en = 1'b1;

    directed(1'b0);
    directed(1'b1);

    // R7: exercising A-to-B leaves the B-to-A output untouched
    select_dir(1'b1);
    set_le(1'b1, 1'b0);
    set_d(1'b1, 18'h0BEEF);
    pulse(1'b1);
    set_d(1'b1, 18'h00000);
    le_ab = 1'b1; ext_a = 18'h3F00F; #1;
    clk_ab = 1'b1; #HALF; clk_ab = 1'b0; #HALF;
    le_ab = 1'b0; #1;
    clk_ab = 1'b1; #HALF; clk_ab = 1'b0; #HALF;
    held_ab = ext_a;
    oe_ab = 1'b0; #1;
    report("R7 B-to-A unaffected", a_out, 18'h0BEEF);
    report("R7 A-to-B kept own value", b_out, 18'h3F00F);

    random_run(1'b0, 400);
    random_run(1'b1, 400);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule